// File: doc/BRIEF.md
# MFM Address Mark Writer and Detector

This block frames the fields of a soft-sectored MFM track. Its write half takes one command per byte on a byte-wide port and turns it into a serial MFM cell stream, one cell per clock. The write half normally inserts a clock cell only between two zero data bits. On command it writes the sync byte 0xA1 with a single clock cell left out on purpose. This produces the cell word 0x4489, which no legal MFM encoding can produce. While it writes, the write half keeps a 16-bit CRC and can append that CRC as two bytes.

The read half watches an incoming serial cell stream for the word 0x4489 at any bit offset. When it finds that word it locks byte alignment. It then classifies the next decoded byte: 0xFE opens an ID field and 0xF8 opens a data field. Any other byte makes it go back to searching. For an accepted field it delivers the body bytes, runs the CRC over the marks, the marker, the body and the two trailing CRC bytes, and reports whether the remainder is zero.

Write state machine: `TX_IDLE` goes to `TX_SEND` on an accepted command. `TX_SEND` stays in `TX_SEND` when a new command is accepted in the last cell of a byte, and otherwise returns to `TX_IDLE` after that cell. Read state machine: `RX_HUNT` goes to `RX_MARK` when it sees the sync word. `RX_MARK` stays in `RX_MARK` on another sync word, goes to `RX_BODY` on a valid marker, and returns to `RX_HUNT` on any other byte. `RX_BODY` goes to `RX_CRC` after the last body byte. `RX_CRC` returns to `RX_HUNT` after the second CRC byte.

Top module: `mfm_mark_codec`

## Requirements
- R1: After reset `wr_ready` is 1, `tx_busy` and `tx_cell` are 0, and every read-side pulse output and `rx_field_id` is 0.
- R2: A command is taken on a clock edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 1 while idle and during the last of the 16 cells of the byte in flight. The 16 cells are sent one per clock, starting in the cycle after acceptance. They go most significant data bit first, and each data bit is preceded by its clock cell. An idle line carries 0.
- R3: Command 0 (`wr_cmd`=0) writes `wr_data` with plain MFM coding. A clock cell is 1 only when the data bit and the data bit before it are both 0. For the first bit, the bit before it is the last data bit written (0 after reset).
- R4: Command 1 writes 0xA1 with the clock cell before data bit 2 (counting from bit 0 as least significant) forced to 0. The result is the cell word 0x4489 instead of 0x44A9.
- R5: The write CRC uses polynomial 0x1021, works most significant bit first, and is preset to 0xFFFF by a command 1 that does not directly follow another command 1. It absorbs every mark byte and every command 0 byte. Command 2 writes its high byte and command 3 writes its low byte, and neither command changes it.
- R6: The reader looks for 0x4489 at every cell offset. Each hit pulses `rx_sync` and aligns bytes to that word. A plainly coded 0xA1 does not count as a hit.
- R7: In the byte after a mark, another 0x4489 keeps alignment. 0xFE pulses `rx_field_start` with `rx_field_id`=1, and 0xF8 pulses it with `rx_field_id`=0. Any other byte pulses `rx_mark_bad`, returns to searching and starts no field.
- R8: An ID field body is `ID_LEN` (4) bytes and a data field body is `DATA_LEN` (256) bytes. Each body byte appears on `rx_data` with a one-cycle `rx_data_valid`.
- R9: After the two CRC bytes, `rx_field_done` pulses with `rx_crc_ok`=1 exactly when the CRC is zero. That CRC is preset to 0xFFFF at the first mark and runs over all marks, the marker, the body and both CRC bytes. The reader then searches again.
- R10: The read-side pulses `rx_sync`, `rx_field_start`, `rx_data_valid`, `rx_field_done` and `rx_mark_bad` last one cycle each, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, one cell per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write command present |
| wr_cmd | input | 2 | 0 data, 1 sync mark, 2 CRC high, 3 CRC low |
| wr_data | input | 8 | Byte for command 0 |
| wr_ready | output | 1 | Command can be taken this cycle |
| tx_cell | output | 1 | Serial write cell stream |
| tx_busy | output | 1 | A byte is being serialised |
| rx_cell | input | 1 | Serial read cell stream |
| rx_sync | output | 1 | Sync word seen |
| rx_field_start | output | 1 | Valid marker byte accepted |
| rx_field_id | output | 1 | 1 for an ID field, 0 for a data field |
| rx_data | output | 8 | Decoded body byte |
| rx_data_valid | output | 1 | `rx_data` is valid |
| rx_field_done | output | 1 | Field CRC bytes received |
| rx_crc_ok | output | 1 | CRC remainder was zero |
| rx_mark_bad | output | 1 | Byte after a mark was not a marker |

## Verification
The write half is checked word by word. Separate tests compare the sync command against a plainly coded 0xA1, compare bytes whose first bit depends on the bit before them, and compare the CRC bytes against a CRC the bench computes itself. The read half is driven in two ways: it reads back the writer's own output, and it reads hand-built streams. The hand-built streams cover a single mark, a triple mark, an ID field, a full data field, a damaged CRC, an unknown marker byte and a plainly coded 0xA1 that must not count as a mark. Together these separate a missing-clock mark from ordinary data, one field kind from the other, and a good CRC from a bad one.

// File: rtl/mfm_mark_pkg.sv
package mfm_mark_pkg;

    localparam int          CELLS_PER_BYTE = 16;
    localparam logic [7:0]  SYNC_BYTE      = 8'hA1;
    localparam logic [7:0]  ID_TAG         = 8'hFE;
    localparam logic [7:0]  DATA_TAG       = 8'hF8;
    localparam logic [15:0] SYNC_CELLS     = 16'h4489;
    localparam logic [15:0] CRC_POLY       = 16'h1021;
    localparam logic [15:0] CRC_SEED       = 16'hFFFF;
    // data bit whose leading clock cell is dropped in a sync mark
    localparam int          GAP_BIT        = 2;

    typedef enum logic [1:0] {
        CMD_DATA   = 2'd0,
        CMD_MARK   = 2'd1,
        CMD_CRC_HI = 2'd2,
        CMD_CRC_LO = 2'd3
    } wr_cmd_e;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_MARK,
        RX_BODY,
        RX_CRC
    } rx_state_e;

    // CRC update with one byte, most significant bit first
    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    // pick the data cells (even positions) out of a 16-cell word
    function automatic logic [7:0] cells_to_byte(input logic [15:0] w);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[i] = w[2*i];
        return b;
    endfunction

endpackage

// File: rtl/mfm_cell_encoder.sv
module mfm_cell_encoder #(
    parameter int GAP = 2
) (
    input  logic [7:0]  data,
    input  logic        prev,
    input  logic        mark,
    output logic [15:0] cells
);
    // chain[i+1] is the data bit written just before data[i]
    logic [8:0] chain;
    assign chain = {prev, data};

    generate
        for (genvar i = 0; i < 8; i++) begin : g_bit
            logic drop;
            logic clk_cell;
            assign drop          = mark && (i == GAP);
            assign clk_cell      = ~chain[i+1] & ~chain[i] & ~drop;
            assign cells[2*i+1]  = clk_cell;
            assign cells[2*i]    = chain[i];
        end
    endgenerate
endmodule

// File: rtl/mfm_tx_framer.sv
module mfm_tx_framer
    import mfm_mark_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [1:0] wr_cmd,
    input  logic [7:0] wr_data,
    output logic       wr_ready,
    output logic       tx_cell,
    output logic       tx_busy
);
    localparam int CNT_W = $clog2(CELLS_PER_BYTE);
    localparam logic [CNT_W-1:0] LAST_CELL = CNT_W'(CELLS_PER_BYTE - 1);

    tx_state_e         state, state_nx;
    logic [CNT_W-1:0]  cell_cnt;
    logic [15:0]       shreg;
    logic [15:0]       crc;
    logic              last_bit;
    logic              after_mark;
    logic              accept;
    logic              last_cell;
    logic [7:0]        sel_byte;
    logic              is_mark;
    logic [15:0]       enc_cells;
    wr_cmd_e           cmd;

    assign cmd       = wr_cmd_e'(wr_cmd);
    assign is_mark   = (cmd == CMD_MARK);
    assign last_cell = (state == TX_SEND) && (cell_cnt == LAST_CELL);
    assign accept    = wr_valid && wr_ready;

    always_comb begin
        unique case (cmd)
            CMD_DATA:   sel_byte = wr_data;
            CMD_MARK:   sel_byte = SYNC_BYTE;
            CMD_CRC_HI: sel_byte = crc[15:8];
            CMD_CRC_LO: sel_byte = crc[7:0];
        endcase
    end

    mfm_cell_encoder #(.GAP(GAP_BIT)) u_enc (
        .data  (sel_byte),
        .prev  (last_bit),
        .mark  (is_mark),
        .cells (enc_cells)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE: if (accept) state_nx = TX_SEND;
            TX_SEND: if (last_cell && !accept) state_nx = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_ready = (state == TX_IDLE) || last_cell;
        tx_busy  = (state == TX_SEND);
        tx_cell  = (state == TX_SEND) ? shreg[15] : 1'b0;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_cnt   <= '0;
            shreg      <= '0;
            crc        <= CRC_SEED;
            last_bit   <= 1'b0;
            after_mark <= 1'b0;
        end else if (accept) begin
            shreg      <= enc_cells;
            cell_cnt   <= '0;
            last_bit   <= sel_byte[0];
            after_mark <= is_mark;
            unique case (cmd)
                CMD_MARK:   crc <= crc_byte(after_mark ? crc : CRC_SEED, SYNC_BYTE);
                CMD_DATA:   crc <= crc_byte(crc, wr_data);
                CMD_CRC_HI,
                CMD_CRC_LO: crc <= crc;
            endcase
        end else if (state == TX_SEND) begin
            shreg    <= {shreg[14:0], 1'b0};
            cell_cnt <= cell_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mfm_rx_framer.sv
module mfm_rx_framer
    import mfm_mark_pkg::*;
#(
    parameter int ID_LEN   = 4,
    parameter int DATA_LEN = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_cell,
    output logic       rx_sync,
    output logic       rx_field_start,
    output logic       rx_field_id,
    output logic [7:0] rx_data,
    output logic       rx_data_valid,
    output logic       rx_field_done,
    output logic       rx_crc_ok,
    output logic       rx_mark_bad
);
    localparam int LEN_MAX = (ID_LEN > DATA_LEN) ? ID_LEN : DATA_LEN;
    localparam int BCNT_W  = $clog2(LEN_MAX + 1);
    localparam int CNT_W   = $clog2(CELLS_PER_BYTE);
    localparam logic [CNT_W-1:0]  LAST_CELL = CNT_W'(CELLS_PER_BYTE - 1);
    localparam logic [BCNT_W-1:0] ID_LAST   = BCNT_W'(ID_LEN - 1);
    localparam logic [BCNT_W-1:0] DATA_LAST = BCNT_W'(DATA_LEN - 1);

    rx_state_e          state, state_nx;
    logic [14:0]        sh;
    logic [15:0]        nxt;
    logic [CNT_W-1:0]   cnt;
    logic [BCNT_W-1:0]  bcnt;
    logic [BCNT_W-1:0]  body_last;
    logic [15:0]        crc;
    logic [15:0]        crc_nx;
    logic               kind_id;
    logic               byte_end;
    logic               mark_hit;
    logic               tag_ok;
    logic [7:0]         cur_byte;

    assign nxt       = {sh, rx_cell};
    assign mark_hit  = (nxt == SYNC_CELLS);
    assign byte_end  = (cnt == LAST_CELL);
    assign cur_byte  = cells_to_byte(nxt);
    assign tag_ok    = (cur_byte == ID_TAG) || (cur_byte == DATA_TAG);
    assign body_last = kind_id ? ID_LAST : DATA_LAST;
    assign crc_nx    = crc_byte(crc, cur_byte);
    assign rx_field_id = kind_id;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_HUNT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_HUNT: if (mark_hit) state_nx = RX_MARK;
            RX_MARK: if (byte_end) begin
                if (mark_hit)    state_nx = RX_MARK;
                else if (tag_ok) state_nx = RX_BODY;
                else             state_nx = RX_HUNT;
            end
            RX_BODY: if (byte_end && bcnt == body_last) state_nx = RX_CRC;
            RX_CRC:  if (byte_end && bcnt == BCNT_W'(1)) state_nx = RX_HUNT;
        endcase
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh             <= '0;
            cnt            <= '0;
            bcnt           <= '0;
            crc            <= CRC_SEED;
            kind_id        <= 1'b0;
            rx_sync        <= 1'b0;
            rx_field_start <= 1'b0;
            rx_data        <= '0;
            rx_data_valid  <= 1'b0;
            rx_field_done  <= 1'b0;
            rx_crc_ok      <= 1'b0;
            rx_mark_bad    <= 1'b0;
        end else begin
            sh             <= nxt[14:0];
            rx_sync        <= 1'b0;
            rx_field_start <= 1'b0;
            rx_data_valid  <= 1'b0;
            rx_field_done  <= 1'b0;
            rx_mark_bad    <= 1'b0;
            unique case (state)
                RX_HUNT: begin
                    if (mark_hit) begin
                        cnt     <= '0;
                        crc     <= crc_byte(CRC_SEED, SYNC_BYTE);
                        rx_sync <= 1'b1;
                    end
                end
                RX_MARK: begin
                    cnt <= cnt + CNT_W'(1);
                    if (byte_end) begin
                        if (mark_hit) begin
                            crc     <= crc_byte(crc, SYNC_BYTE);
                            rx_sync <= 1'b1;
                        end else if (tag_ok) begin
                            crc            <= crc_nx;
                            kind_id        <= (cur_byte == ID_TAG);
                            bcnt           <= '0;
                            rx_field_start <= 1'b1;
                        end else begin
                            rx_mark_bad <= 1'b1;
                        end
                    end
                end
                RX_BODY: begin
                    cnt <= cnt + CNT_W'(1);
                    if (byte_end) begin
                        crc           <= crc_nx;
                        rx_data       <= cur_byte;
                        rx_data_valid <= 1'b1;
                        bcnt          <= (bcnt == body_last) ? '0 : bcnt + BCNT_W'(1);
                    end
                end
                RX_CRC: begin
                    cnt <= cnt + CNT_W'(1);
                    if (byte_end) begin
                        crc  <= crc_nx;
                        bcnt <= bcnt + BCNT_W'(1);
                        if (bcnt == BCNT_W'(1)) begin
                            rx_field_done <= 1'b1;
                            rx_crc_ok     <= (crc_nx == 16'h0000);
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mfm_mark_codec.sv
module mfm_mark_codec #(
    parameter int ID_LEN   = 4,
    parameter int DATA_LEN = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [1:0] wr_cmd,
    input  logic [7:0] wr_data,
    output logic       wr_ready,
    output logic       tx_cell,
    output logic       tx_busy,
    input  logic       rx_cell,
    output logic       rx_sync,
    output logic       rx_field_start,
    output logic       rx_field_id,
    output logic [7:0] rx_data,
    output logic       rx_data_valid,
    output logic       rx_field_done,
    output logic       rx_crc_ok,
    output logic       rx_mark_bad
);
    mfm_tx_framer u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_cmd   (wr_cmd),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .tx_cell  (tx_cell),
        .tx_busy  (tx_busy)
    );

    mfm_rx_framer #(.ID_LEN(ID_LEN), .DATA_LEN(DATA_LEN)) u_rx (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_cell        (rx_cell),
        .rx_sync        (rx_sync),
        .rx_field_start (rx_field_start),
        .rx_field_id    (rx_field_id),
        .rx_data        (rx_data),
        .rx_data_valid  (rx_data_valid),
        .rx_field_done  (rx_field_done),
        .rx_crc_ok      (rx_crc_ok),
        .rx_mark_bad    (rx_mark_bad)
    );
endmodule

// File: rtl/mfm_mark_codec_chk.sv
module mfm_mark_codec_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic wr_ready,
    input logic tx_busy,
    input logic tx_cell,
    input logic rx_sync,
    input logic rx_field_start,
    input logic rx_data_valid,
    input logic rx_field_done,
    input logic rx_mark_bad
);
    // R2: an idle writer always takes a command
    a_r2_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> wr_ready);

    // R2: an accepted command makes the writer busy in the next cycle
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> tx_busy);

    // R2: the idle line carries no cells
    a_r2_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !tx_cell);

    // R10: read-side pulses never overlap
    a_r10_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_sync, rx_field_start, rx_data_valid, rx_field_done, rx_mark_bad}));

    // R8: body bytes are a byte time apart, never back to back
    a_r8_byte_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rx_data_valid |=> !rx_data_valid);

    // R7: the first body byte cannot follow a field start directly
    a_r7_start_gap: assert property (@(posedge clk) disable iff (!rst_n)
        rx_field_start |=> !(rx_field_start || rx_data_valid));

    // R9: completion is followed by no body byte in the next cycle
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rx_field_done |=> !(rx_data_valid || rx_field_done));
endmodule

bind mfm_mark_codec mfm_mark_codec_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_valid       (wr_valid),
    .wr_ready       (wr_ready),
    .tx_busy        (tx_busy),
    .tx_cell        (tx_cell),
    .rx_sync        (rx_sync),
    .rx_field_start (rx_field_start),
    .rx_data_valid  (rx_data_valid),
    .rx_field_done  (rx_field_done),
    .rx_mark_bad    (rx_mark_bad)
);

// File: tb/sim_mfm_mark_codec.sv
module sim_mfm_mark_codec;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [1:0] wr_cmd = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       wr_ready, tx_cell, tx_busy;
    logic       rx_cell;
    logic       rx_sync, rx_field_start, rx_field_id, rx_data_valid;
    logic       rx_field_done, rx_crc_ok, rx_mark_bad;
    logic [7:0] rx_data;
    logic       use_loop = 1'b0;
    logic       drv_cell = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int n_sync = 0;
    int n_markbad = 0;

    bit       exp_kind[$];
    bit [7:0] exp_byte[$];
    bit       exp_ok[$];

    logic     bprev = 1'b0;
    logic [15:0] bcrc;

    assign rx_cell = use_loop ? tx_cell : drv_cell;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfm_mark_codec u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_cmd(wr_cmd),
        .wr_data(wr_data), .wr_ready(wr_ready), .tx_cell(tx_cell), .tx_busy(tx_busy),
        .rx_cell(rx_cell), .rx_sync(rx_sync), .rx_field_start(rx_field_start),
        .rx_field_id(rx_field_id), .rx_data(rx_data), .rx_data_valid(rx_data_valid),
        .rx_field_done(rx_field_done), .rx_crc_ok(rx_crc_ok), .rx_mark_bad(rx_mark_bad)
    );

    function automatic logic [15:0] b_enc(input logic [7:0] b, input logic p, input logic mk);
        logic [15:0] w;
        logic q;
        q = p;
        for (int i = 7; i >= 0; i--) begin
            w[2*i+1] = (!q && !b[i] && !(mk && i == 2));
            w[2*i]   = b[i];
            q = b[i];
        end
        return w;
    endfunction

    function automatic logic [15:0] b_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = r[15] ^ b[i];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_sync) n_sync++;
            if (rx_mark_bad) n_markbad++;
            if (rx_field_start) begin
                if (exp_kind.size() == 0) chk("R7 unexpected field start", 1, 0);
                else chk("R7 field kind", rx_field_id, exp_kind.pop_front());
            end
            if (rx_data_valid) begin
                if (exp_byte.size() == 0) chk("R8 unexpected body byte", 1, 0);
                else chk("R8 body byte", rx_data, exp_byte.pop_front());
            end
            if (rx_field_done) begin
                if (exp_ok.size() == 0) chk("R9 unexpected field done", 1, 0);
                else chk("R9 crc verdict", rx_crc_ok, exp_ok.pop_front());
            end
        end
    end

    task automatic wr(input logic [1:0] cmd, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_cmd = cmd; wr_data = d;
        while (!wr_ready) @(negedge clk);
        @(posedge clk);
        #1 wr_valid = 1'b0;
    endtask

    task automatic wr_cap(input logic [1:0] cmd, input logic [7:0] d, output logic [15:0] w);
        wr(cmd, d);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            w[15-k] = tx_cell;
        end
    endtask

    task automatic drive_byte(input logic [7:0] b, input logic mk);
        logic [15:0] w;
        w = b_enc(b, bprev, mk);
        bprev = b[0];
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            drv_cell = w[15-k];
        end
    endtask

    task automatic drive_field(input int nmarks, input logic [7:0] tag, input int len,
                               input int seed, input logic corrupt);
        logic [15:0] c;
        logic [7:0]  b;
        c = 16'hFFFF;
        for (int i = 0; i < 3; i++) drive_byte(8'h4E, 1'b0);
        for (int i = 0; i < nmarks; i++) begin
            drive_byte(8'hA1, 1'b1);
            c = b_crc(c, 8'hA1);
        end
        drive_byte(tag, 1'b0);
        c = b_crc(c, tag);
        exp_kind.push_back(tag == 8'hFE);
        for (int i = 0; i < len; i++) begin
            b = 8'((i * 37 + seed) & 255);
            drive_byte(b, 1'b0);
            c = b_crc(c, b);
            exp_byte.push_back(b);
        end
        if (corrupt) c = c ^ 16'h0100;
        drive_byte(c[15:8], 1'b0);
        drive_byte(c[7:0], 1'b0);
        exp_ok.push_back(!corrupt);
        for (int i = 0; i < 2; i++) drive_byte(8'h4E, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] w;
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 wr_ready", wr_ready, 1);
        chk("R1 tx_busy", tx_busy, 0);
        chk("R1 tx_cell", tx_cell, 0);
        chk("R1 rx pulses", {rx_sync, rx_field_start, rx_data_valid, rx_field_done,
                             rx_mark_bad, rx_field_id}, 0);

        // R4 mark word from idle, CRC preset
        bcrc = b_crc(16'hFFFF, 8'hA1);
        wr_cap(2'd1, 8'h00, w);
        chk("R4 sync cell word", w, 16'h4489);
        @(negedge clk);
        chk("R2 idle after byte", {tx_busy, wr_ready}, 2'b01);

        // R3 plain bytes, first clock depends on previous bit
        wr_cap(2'd0, 8'h00, w);
        chk("R3 byte 00 after a 1", w, b_enc(8'h00, 1'b1, 1'b0));
        bcrc = b_crc(bcrc, 8'h00);
        wr_cap(2'd0, 8'h4E, w);
        chk("R3 byte 4E after a 0", w, b_enc(8'h4E, 1'b0, 1'b0));
        bcrc = b_crc(bcrc, 8'h4E);

        // R5 CRC bytes
        wr_cap(2'd2, 8'h00, w);
        chk("R5 crc high", w, b_enc(bcrc[15:8], 1'b0, 1'b0));
        wr_cap(2'd3, 8'h00, w);
        chk("R5 crc low", w, b_enc(bcrc[7:0], bcrc[8], 1'b0));

        // R3/R4 plain A1 differs from mark
        wr_cap(2'd0, 8'hA1, w);
        chk("R3 plain A1 word", w, 16'h44A9);

        // R2 back-to-back continuity: ready only in last cell
        wr(2'd0, 8'hFF);
        @(negedge clk);
        chk("R2 not ready mid byte", {tx_busy, wr_ready}, 2'b10);
        repeat (20) @(negedge clk);

        // loopback ID field with triple mark
        use_loop = 1'b1;
        s0 = n_sync;
        exp_kind.push_back(1'b1);
        for (int i = 0; i < 3; i++) wr(2'd0, 8'h4E);
        for (int i = 0; i < 3; i++) wr(2'd1, 8'h00);
        wr(2'd0, 8'hFE);
        for (int i = 0; i < 4; i++) begin
            wr(2'd0, 8'(8'h10 + i));
            exp_byte.push_back(8'(8'h10 + i));
        end
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        exp_ok.push_back(1'b1);
        wr(2'd0, 8'h4E);
        wr(2'd0, 8'h4E);
        repeat (60) @(negedge clk);
        chk("R6 three sync pulses in loopback", n_sync - s0, 3);
        chk("R5 loopback queues drained", exp_kind.size() + exp_byte.size() + exp_ok.size(), 0);
        use_loop = 1'b0;

        // direct stream: data field, good CRC
        repeat (20) @(negedge clk);
        bprev = 1'b0;
        drive_field(3, 8'hF8, 256, 5, 1'b0);
        repeat (20) @(negedge clk);
        chk("R8 data field drained", exp_kind.size() + exp_byte.size() + exp_ok.size(), 0);

        // single mark ID field, bad CRC
        s0 = n_sync;
        drive_field(1, 8'hFE, 4, 99, 1'b1);
        repeat (20) @(negedge clk);
        chk("R6 single sync pulse", n_sync - s0, 1);
        chk("R9 bad crc field drained", exp_kind.size() + exp_byte.size() + exp_ok.size(), 0);

        // R7 unknown marker byte
        s0 = n_markbad;
        for (int i = 0; i < 2; i++) drive_byte(8'h4E, 1'b0);
        drive_byte(8'hA1, 1'b1);
        drive_byte(8'hFB, 1'b0);
        for (int i = 0; i < 3; i++) drive_byte(8'h4E, 1'b0);
        repeat (5) @(negedge clk);
        chk("R7 bad marker flagged", n_markbad - s0, 1);

        // R6 plain A1 is not a mark
        s0 = n_sync;
        drive_byte(8'hA1, 1'b0);
        drive_byte(8'hFE, 1'b0);
        for (int i = 0; i < 3; i++) drive_byte(8'h4E, 1'b0);
        repeat (5) @(negedge clk);
        chk("R6 plain A1 gives no sync", n_sync - s0, 0);
        chk("R7 no field after plain A1", exp_kind.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule